// File: doc/BRIEF.md
# Saturating Doubling Multiply-Long Datapath

This block is the execute stage for a packed signed multiply that widens its results. Two 128-bit source vectors arrive with a 2-bit element-size code. In vector mode one 64-bit half of each source is chosen by a half-select input, corresponding signed elements are multiplied, each product is doubled, and the double-width results fill the whole 128-bit destination. In scalar mode only the lowest element of each source is used, and the destination bits above the single result are zero.

Doubling a widened product can overflow in exactly one case: both inputs hold the most negative element value. That lane is clamped to the largest positive double-width value, and a sticky saturation flag is raised. The flag stays set until software clears it through a synchronous clear input. A size code that names no legal element width is reported on an undefined-operation output, and the destination is left unchanged. Results appear one clock after a valid input, and an output-valid strobe marks them.

Top module: `sat_dbl_mul_long`

## Requirements
- R1: sizeSel 2'b01 selects 16-bit elements and 2'b10 selects 32-bit elements. For 2'b00 or 2'b11, undefOp is 1 together with outValid, and dest and qcFlag keep their previous values.
- R2: In vector mode (scalarMode=0), 16-bit operation gives four lanes and 32-bit operation gives two. Result lane e occupies dest[e*2w +: 2w], where w is the element width, and the element feeding lane e is source bits [e*w +: w] of the chosen half.
- R3: In vector mode, upperHalf=0 takes both sources from bits 63:0, and upperHalf=1 takes both from bits 127:64.
- R4: Each lane's result is the signed value 2*a*b, with a and b read as two's-complement elements.
- R5: When both elements of a lane equal the most negative value, that lane outputs the largest positive double-width value: 32'h7FFFFFFF for 16-bit elements and 64'h7FFFFFFFFFFFFFFF for 32-bit elements. No other input pair saturates.
- R6: In scalar mode (scalarMode=1), only bits [w-1:0] of each source are used, whatever upperHalf is. The result fills dest[2w-1:0], the bits above it are written as zero, and a saturating pair in any other element position leaves qcFlag unchanged.
- R7: qcFlag goes to 1 one cycle after an accepted legal operation in which any used lane saturates. It then stays at 1 until qcClear is sampled high, which clears it on the next edge. If a saturating operation and qcClear arrive in the same cycle, the flag ends up 1.
- R8: outValid is 1 in exactly the cycle after inValid was sampled high, and dest changes only at that edge, and only for a legal size.
- R9: While rstN is low, dest, outValid, undefOp and qcFlag are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Operation request for this cycle |
| scalarMode | input | 1 | 1 = single lowest element, 0 = vector |
| upperHalf | input | 1 | Vector half select: 0 = bits 63:0, 1 = bits 127:64 |
| sizeSel | input | 2 | Element-size code (01 = 16-bit, 10 = 32-bit) |
| srcA | input | 128 | First source vector |
| srcB | input | 128 | Second source vector |
| qcClear | input | 1 | Synchronous clear of the saturation flag |
| outValid | output | 1 | Result (or undefined report) is present |
| undefOp | output | 1 | The last request had an illegal size code |
| dest | output | 128 | Packed double-width results |
| qcFlag | output | 1 | Sticky cumulative saturation flag |

## Verification
The bench aims at the most-negative-times-most-negative pair in both element widths. A datapath that doubled without clamping would return the most negative value there and leave the flag low. It mixes saturating and ordinary lanes in one vector, so a design that clamped every lane or shifted lanes into the wrong slot would show a wrong word. Scalar requests are issued with upperHalf set and with a saturating pair outside the lowest element: a design that honoured the half select, left stale upper bits or took the flag from unused lanes would be caught. Illegal size codes, a clear alone, and a clear in the same cycle as a saturating operation show whether the destination is held and whether set wins over clear.

// File: rtl/sdml_pkg.sv
package sdml_pkg;

  typedef enum logic [1:0] {
    SZ_RSV_LO = 2'b00,
    SZ_HALF   = 2'b01,
    SZ_WORD   = 2'b10,
    SZ_RSV_HI = 2'b11
  } sizeCodeT;

  // strobes from control to datapath
  typedef struct packed {
    logic loadDest;  // accepted legal operation this cycle
    logic wide;      // 32-bit elements
    logic scalar;    // single lowest element
    logic upper;     // upper 64-bit half
    logic clrQc;     // synchronous flag clear
  } ctrlStrobeT;

endpackage

// File: rtl/sdml_lane.sv
module sdml_lane #(
  parameter int EW = 16
) (
  input  logic [EW-1:0]   a,
  input  logic [EW-1:0]   b,
  output logic [2*EW-1:0] res,
  output logic            sat
);
  localparam int RW = 2 * EW;
  localparam logic [EW-1:0] MIN_VAL = {1'b1, {(EW-1){1'b0}}};
  localparam logic [RW-1:0] MAX_RES = {1'b0, {(RW-1){1'b1}}};

  logic signed [RW-1:0] aExt;
  logic signed [RW-1:0] bExt;
  logic signed [RW-1:0] prod;

  always_comb begin
    aExt = {{EW{a[EW-1]}}, a};
    bExt = {{EW{b[EW-1]}}, b};
    prod = aExt * bExt;
    sat  = (a == MIN_VAL) && (b == MIN_VAL);
    res  = sat ? MAX_RES : (prod <<< 1);
  end

  // the clamped value is positive; any other doubled product keeps the product's sign
  always_comb begin
    if (sat) begin
      AST_SAT_POSITIVE: assert (res[RW-1] == 1'b0); // R5
    end
  end

endmodule

// File: rtl/sdml_ctrl.sv
module sdml_ctrl
  import sdml_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       scalarMode,
  input  logic       upperHalf,
  input  logic [1:0] sizeSel,
  input  logic       qcClear,
  output ctrlStrobeT strobe,
  output logic       outValid,
  output logic       undefOp
);
  logic legalSize;

  always_comb begin
    legalSize       = (sizeSel == SZ_HALF) || (sizeSel == SZ_WORD);
    strobe.loadDest = inValid && legalSize;
    strobe.wide     = (sizeSel == SZ_WORD);
    strobe.scalar   = scalarMode;
    strobe.upper    = upperHalf;
    strobe.clrQc    = qcClear;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      undefOp  <= 1'b0;
    end else begin
      outValid <= inValid;
      undefOp  <= inValid && !legalSize;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R8
  AST_VALID_ONLY_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid); // R8
  AST_UNDEF_WITH_VALID: assert property (@(posedge clk) disable iff (!rstN)
    undefOp |-> outValid); // R1

endmodule

// File: rtl/sdml_datapath.sv
module sdml_datapath
  import sdml_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobeT       strobe,
  input  logic [VEC_W-1:0] srcA,
  input  logic [VEC_W-1:0] srcB,
  output logic [VEC_W-1:0] dest,
  output logic             qcFlag
);
  localparam int HALF_W = VEC_W / 2;
  localparam int NH     = HALF_W / 16;
  localparam int NW     = HALF_W / 32;

  logic             takeUpper;
  logic [HALF_W-1:0] opA;
  logic [HALF_W-1:0] opB;
  logic [VEC_W-1:0] resH;
  logic [VEC_W-1:0] resW;
  logic [NH-1:0]    satH;
  logic [NW-1:0]    satW;
  logic [VEC_W-1:0] outH;
  logic [VEC_W-1:0] outW;
  logic [VEC_W-1:0] nextDest;
  logic             satAny;

  always_comb begin
    takeUpper = strobe.upper && !strobe.scalar;
    opA = takeUpper ? srcA[VEC_W-1:HALF_W] : srcA[HALF_W-1:0];
    opB = takeUpper ? srcB[VEC_W-1:HALF_W] : srcB[HALF_W-1:0];
  end

  for (genvar g = 0; g < NH; g++) begin : g_half
    sdml_lane #(.EW(16)) i_lane (
      .a  (opA[g*16 +: 16]),
      .b  (opB[g*16 +: 16]),
      .res(resH[g*32 +: 32]),
      .sat(satH[g])
    );
  end

  for (genvar g = 0; g < NW; g++) begin : g_word
    sdml_lane #(.EW(32)) i_lane (
      .a  (opA[g*32 +: 32]),
      .b  (opB[g*32 +: 32]),
      .res(resW[g*64 +: 64]),
      .sat(satW[g])
    );
  end

  always_comb begin
    outH = strobe.scalar ? {{(VEC_W-32){1'b0}}, resH[31:0]} : resH;
    outW = strobe.scalar ? {{(VEC_W-64){1'b0}}, resW[63:0]} : resW;
    nextDest = strobe.wide ? outW : outH;
    if (strobe.wide) satAny = strobe.scalar ? satW[0] : |satW;
    else             satAny = strobe.scalar ? satH[0] : |satH;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dest <= '0;
    end else if (strobe.loadDest) begin
      dest <= nextDest;
    end
  end

  // set has priority over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qcFlag <= 1'b0;
    end else if (strobe.loadDest && satAny) begin
      qcFlag <= 1'b1;
    end else if (strobe.clrQc) begin
      qcFlag <= 1'b0;
    end
  end

  AST_QC_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    qcFlag && !strobe.clrQc |=> qcFlag); // R7
  AST_QC_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(qcFlag) |-> $past(strobe.loadDest)); // R7
  AST_DEST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadDest |=> $stable(dest)); // R8
  AST_SCALAR_HI_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadDest && strobe.scalar && !strobe.wide |=> dest[VEC_W-1:32] == '0); // R6

endmodule

// File: rtl/sat_dbl_mul_long.sv
module sat_dbl_mul_long
  import sdml_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             scalarMode,
  input  logic             upperHalf,
  input  logic [1:0]       sizeSel,
  input  logic [VEC_W-1:0] srcA,
  input  logic [VEC_W-1:0] srcB,
  input  logic             qcClear,
  output logic             outValid,
  output logic             undefOp,
  output logic [VEC_W-1:0] dest,
  output logic             qcFlag
);
  ctrlStrobeT strobe;

  sdml_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .scalarMode(scalarMode),
    .upperHalf (upperHalf),
    .sizeSel   (sizeSel),
    .qcClear   (qcClear),
    .strobe    (strobe),
    .outValid  (outValid),
    .undefOp   (undefOp)
  );

  sdml_datapath #(.VEC_W(VEC_W)) i_datapath (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .srcA  (srcA),
    .srcB  (srcB),
    .dest  (dest),
    .qcFlag(qcFlag)
  );

  AST_UNDEF_KEEPS_DEST: assert property (@(posedge clk) disable iff (!rstN)
    undefOp |-> $stable(dest)); // R1

endmodule

// File: tb/test_sat_dbl_mul_long.sv
`timescale 1ns/1ps
module test_sat_dbl_mul_long;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic         scalarMode = 1'b0;
  logic         upperHalf = 1'b0;
  logic [1:0]   sizeSel = 2'b01;
  logic [127:0] srcA = '0;
  logic [127:0] srcB = '0;
  logic         qcClear = 1'b0;
  logic         outValid;
  logic         undefOp;
  logic [127:0] dest;
  logic         qcFlag;

  int checks = 0;
  int errors = 0;
  logic [127:0] expDest = '0;
  logic         expQc = 1'b0;

  always #10 clk = ~clk;

  sat_dbl_mul_long i_sat_dbl_mul_long (
    .clk(clk), .rstN(rstN), .inValid(inValid), .scalarMode(scalarMode),
    .upperHalf(upperHalf), .sizeSel(sizeSel), .srcA(srcA), .srcB(srcB),
    .qcClear(qcClear), .outValid(outValid), .undefOp(undefOp),
    .dest(dest), .qcFlag(qcFlag)
  );

  typedef struct packed {
    logic         sc;
    logic         up;
    logic [1:0]   sz;
    logic [127:0] a;
    logic [127:0] b;
  } stimT;

  localparam int NSTIM = 8;
  localparam stimT TBL [NSTIM] = '{
    // R2 R4: 16-bit lanes, lower half
    '{1'b0, 1'b0, 2'b01, 128'hDEAD_BEEF_CAFE_F00D_0003_FFFF_7FFF_0002,
                         128'h1111_2222_3333_4444_0005_FFFF_8001_FFFD},
    // R3: 16-bit lanes, upper half
    '{1'b0, 1'b1, 2'b01, 128'h1234_8001_7FFF_FFFE_0000_0000_0000_0000,
                         128'h0010_7FFF_7FFF_0003_FFFF_FFFF_FFFF_FFFF},
    // R2 R4: 32-bit lanes, lower half
    '{1'b0, 1'b0, 2'b10, 128'h0000_0001_0000_0001_7FFF_FFFF_FFFF_FFFE,
                         128'h0000_0002_0000_0002_8000_0000_0001_0000},
    // R3: 32-bit lanes, upper half
    '{1'b0, 1'b1, 2'b10, 128'h8000_0001_0001_2345_0000_0000_0000_0000,
                         128'h8000_0001_FFFF_FFF0_1111_1111_1111_1111},
    // R6: scalar 16-bit, upperHalf ignored
    '{1'b1, 1'b1, 2'b01, 128'h7777_6666_5555_4444_3333_2222_1111_FFF9,
                         128'h1234_5678_9ABC_DEF0_0F0F_F0F0_AAAA_0007},
    // R6: scalar 32-bit
    '{1'b1, 1'b0, 2'b10, 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_8000_0001,
                         128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_7FFF_FFFF},
    // R4: 16-bit mixed signs, upper half
    '{1'b0, 1'b1, 2'b01, 128'h8000_7FFF_0000_FFFF_0000_0000_0000_0000,
                         128'h7FFF_8000_1234_0001_5555_5555_5555_5555},
    // R4: 32-bit extreme non-saturating pair
    '{1'b0, 1'b0, 2'b10, 128'h0000_0000_0000_0000_7FFF_FFFF_8000_0000,
                         128'h0000_0000_0000_0000_7FFF_FFFF_7FFF_FFFF}
  };

  // reference model: 64-bit integer arithmetic with explicit clamping
  function automatic void refOp(input logic sc, input logic up, input logic [1:0] sz,
                                input logic [127:0] a, input logic [127:0] b,
                                output logic [127:0] r, output logic s);
    int w;
    int n;
    int base;
    longint x;
    longint y;
    longint xy;
    longint lim;
    longint maxv;
    longint val;
    r = '0;
    s = 1'b0;
    w = (sz == 2'b01) ? 16 : 32;
    n = sc ? 1 : 64 / w;
    base = (up && !sc) ? 64 : 0;
    lim = (longint'(1) <<< (2 * w - 2)) - 1;
    maxv = (w == 16) ? 64'h0000_0000_7FFF_FFFF : 64'h7FFF_FFFF_FFFF_FFFF;
    for (int e = 0; e < n; e++) begin
      if (w == 16) begin
        x = longint'($signed(a[base + e*16 +: 16]));
        y = longint'($signed(b[base + e*16 +: 16]));
      end else begin
        x = longint'($signed(a[base + e*32 +: 32]));
        y = longint'($signed(b[base + e*32 +: 32]));
      end
      xy = x * y;
      if (xy > lim) begin
        s = 1'b1;
        val = maxv;
      end else begin
        val = 2 * xy;
      end
      if (w == 16) r[e*32 +: 32] = val[31:0];
      else         r[e*64 +: 64] = val;
    end
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic runOp(input string tag, input logic sc, input logic up, input logic [1:0] sz,
                       input logic [127:0] a, input logic [127:0] b, input logic clr);
    logic [127:0] r;
    logic s;
    logic legal;
    @(negedge clk);
    inValid = 1'b1; scalarMode = sc; upperHalf = up; sizeSel = sz;
    srcA = a; srcB = b; qcClear = clr;
    @(negedge clk);
    inValid = 1'b0; qcClear = 1'b0;
    legal = (sz == 2'b01) || (sz == 2'b10);
    if (legal) begin
      refOp(sc, up, sz, a, b, r, s);
      expDest = r;
      expQc = expQc | s;
      if (clr && !s) expQc = 1'b0;
    end else if (clr) begin
      expQc = 1'b0;
    end
    chk({tag, " R8 outValid"}, {127'd0, outValid}, 128'd1);
    chk({tag, " R1 undefOp"}, {127'd0, undefOp}, {127'd0, !legal});
    chk({tag, " dest"}, dest, expDest);
    chk({tag, " R7 qcFlag"}, {127'd0, qcFlag}, {127'd0, expQc});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 dest", dest, '0);
    chk("R9 outValid", {127'd0, outValid}, '0);
    chk("R9 undefOp", {127'd0, undefOp}, '0);
    chk("R9 qcFlag", {127'd0, qcFlag}, '0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NSTIM; i++) begin
      runOp($sformatf("R2 R4 table[%0d]", i), TBL[i].sc, TBL[i].up, TBL[i].sz,
            TBL[i].a, TBL[i].b, 1'b0);
    end

    // R8: idle cycle, no valid and dest held
    @(negedge clk);
    chk("R8 idle outValid", {127'd0, outValid}, '0);
    chk("R8 idle dest", dest, expDest);

    // R6: scalar with a saturating pair in element 1 only, flag must stay low
    runOp("R6 scalar unused sat", 1'b1, 1'b0, 2'b01,
          128'h0000_0000_0000_0000_0000_0000_8000_0004,
          128'h0000_0000_0000_0000_0000_0000_8000_0005, 1'b0);

    // R5: 16-bit min*min mixed with ordinary lanes
    runOp("R5 sat16", 1'b0, 1'b0, 2'b01,
          128'h0000_0000_0000_0000_8000_1234_8000_FFFF,
          128'h0000_0000_0000_0000_8000_0002_0001_FFFF, 1'b0);
    chk("R5 lane0 clamp", {96'd0, dest[31:0]}, {96'd0, 32'h0000_0002});
    chk("R5 lane3 clamp", {96'd0, dest[127:96]}, {96'd0, 32'h7FFF_FFFF});

    // R1: illegal sizes hold dest and flag
    runOp("R1 size00", 1'b0, 1'b0, 2'b00, '1, '1, 1'b0);
    runOp("R1 size11", 1'b0, 1'b1, 2'b11, 128'h5, 128'h7, 1'b0);

    // R7: clear alone
    @(negedge clk); qcClear = 1'b1;
    @(negedge clk); qcClear = 1'b0; expQc = 1'b0;
    chk("R7 clear", {127'd0, qcFlag}, '0);

    // R5 R6: scalar 32-bit min*min
    runOp("R5 sat32 scalar", 1'b1, 1'b1, 2'b10,
          128'h0000_0000_0000_0000_0000_0000_8000_0000,
          128'h0000_0000_0000_0000_0000_0000_8000_0000, 1'b0);
    chk("R5 sat32 value", dest, {64'd0, 64'h7FFF_FFFF_FFFF_FFFF});

    // R7: flag stays set across a non-saturating op, then set wins over clear
    runOp("R7 sticky", 1'b0, 1'b0, 2'b10, 128'h3, 128'h4, 1'b0);
    @(negedge clk); qcClear = 1'b1;
    @(negedge clk); qcClear = 1'b0; expQc = 1'b0;
    runOp("R7 set beats clear", 1'b0, 1'b1, 2'b10,
          128'h8000_0000_0000_0000_0000_0000_0000_0000,
          128'h8000_0000_0000_0000_0000_0000_0000_0000, 1'b1);

    // R9: reset again clears everything
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    chk("R9 re-reset dest", dest, '0);
    chk("R9 re-reset qcFlag", {127'd0, qcFlag}, '0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule